// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Unit

This purely combinational block works on 80-bit extended-precision operands. Each operand has a sign bit at position 79, a 15-bit biased exponent in bits 78:64 and a 64-bit significand in bits 63:0 whose top bit is an explicit integer bit. The unit compares two operands and returns two things. The first is the floating-point condition-code pattern at the bit positions it takes in the floating-point status word. The second is the equivalent pattern in the integer flags word. A comparison that involves a NaN is reported as unordered, and an invalid-operation indication is raised according to the selected comparison mode.

The same unit also classifies the first operand into one of five classes: NaN, infinity, zero, denormal or normal. The class is reported as a status-word pattern that also carries the operand's sign. Every output is a raw bit vector that holds only the bits the block owns. The caller clears those bits in its own status or flags register and ORs the vector in. The compare bits are bits 14, 10 and 8 of the status word, and the class bits are bits 14, 10, 9 and 8.

Top module: `xcc_compare_classify`

## Requirements
- R1: When opA is ordered and below opB, cmpCond is 0x0100 (C0, bit 8) and cmpFlags is 0x01 (carry flag, bit 0). Operands with the same sign are ordered by exponent first and then by significand.
- R2: When the operands are ordered and equal, cmpCond is 0x4000 (C3, bit 14) and cmpFlags is 0x40 (zero flag, bit 6). A positive zero and a negative zero (exponent 0, significand 0) compare equal.
- R3: When opA is ordered and above opB, both cmpCond and cmpFlags are zero. This includes an infinity compared with a finite value of the same sign.
- R4: A NaN is any operand with exponent 0x7FFF and a significand other than 0x8000000000000000. When either operand is a NaN, the result is unordered: cmpCond is 0x4500 (C3, C2 at bit 10, and C0) and cmpFlags is 0x45 (zero, parity at bit 2, and carry).
- R5: cmpCond never drives a bit outside mask 0x4500, and cmpFlags never drives a bit outside mask 0x45. Carry follows C0, parity follows C2 and zero follows C3.
- R6: When the signs differ and the operands are not both zero, the negative operand is the lower one. When both operands are negative, the magnitude order is inverted.
- R7: With quietCmp = 0 (signalling compare), cmpInvalid is 1 whenever either operand is a NaN. cmpInvalid is 0 whenever the result is ordered.
- R8: With quietCmp = 1 (quiet compare), cmpInvalid is 1 only when an operand is a signalling NaN, meaning a NaN whose significand bit 62 is 0. A quiet NaN still gives the unordered result of R4 but leaves cmpInvalid at 0.
- R9: An opA with exponent 0x7FFF and significand 0x8000000000000000 classifies as infinity: classCond bits 10 and 8 are set (0x0500).
- R10: Any other opA with exponent 0x7FFF, including a significand of 0, classifies as NaN: classCond bit 8 is set (0x0100).
- R11: An opA with exponent 0 classifies as zero (0x4000) when the significand is 0, and as denormal (0x4400) otherwise.
- R12: Every other opA classifies as normal: classCond bit 10 is set (0x0400).
- R13: classCond bit 9 equals the sign of opA. classCond drives no bit outside mask 0x4700.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 80 | First compare operand; also the operand that is classified |
| opB | input | 80 | Second compare operand |
| quietCmp | input | 1 | 1 = quiet compare, 0 = signalling compare |
| cmpCond | output | 16 | Compare result at status-word positions (bits 14, 10, 8) |
| cmpFlags | output | 8 | Compare result at integer-flag positions (bits 6, 2, 0) |
| cmpInvalid | output | 1 | Invalid-operation indication for the comparison |
| classCond | output | 16 | Class code of opA with its sign in bit 9 |

## Verification
The bound checker evaluates a set of cross-output properties whenever an input changes:
- Both result vectors stay inside their masks, and the flag pattern mirrors the condition pattern.
- An invalid indication only ever comes with an unordered result, and a signalling compare against a NaN always raises it.
- An operand compared with itself is equal unless it is a NaN.
- The class sign bit follows opA, and the class code is always one of the five legal codes.

Some behaviour depends on the particular values chosen, so only the bench's vectors can show it:
- the ordering of values with mixed signs and of two negative values;
- a one-ulp difference in the significand;
- the split between quiet and signalling NaNs in quiet mode;
- the placement of each class boundary.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
  localparam int C0_POS = 8;
  localparam int C1_POS = 9;
  localparam int C2_POS = 10;
  localparam int C3_POS = 14;
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int ZF_POS = 6;
  localparam int STAT_W = 16;
  localparam int FLAG_W = 8;

  // per-operand facts needed by the compare decision
  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic isZero;
    logic sign;
  } cmpInfo_t;

  // facts needed to classify the first operand
  typedef struct packed {
    logic isNan;
    logic isInf;
    logic isZero;
    logic isDenorm;
  } clsInfo_t;

  typedef enum logic [2:0] {
    CLS_NORMAL = 3'd0,
    CLS_ZERO   = 3'd1,
    CLS_DENORM = 3'd2,
    CLS_INF    = 3'd3,
    CLS_NAN    = 3'd4
  } clsKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     selLess;
    logic     selEqual;
    logic     selUnord;
    logic     raiseInv;
    clsKind_t clsKind;
  } xccStrobe_t;
endpackage

// File: rtl/xcc_datapath.sv
module xcc_datapath
  import xcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [1+EXP_W+SIG_W-1:0] opA,
  input  logic [1+EXP_W+SIG_W-1:0] opB,
  input  xccStrobe_t               strobe,
  output cmpInfo_t                 infoA,
  output cmpInfo_t                 infoB,
  output clsInfo_t                 clsA,
  output logic                     magLess,
  output logic                     magEqual,
  output logic [STAT_W-1:0]        cmpCond,
  output logic [FLAG_W-1:0]        cmpFlags,
  output logic [STAT_W-1:0]        classCond
);
  localparam int OP_W    = 1 + EXP_W + SIG_W;
  localparam int QBIT    = SIG_W - 2;
  localparam logic [SIG_W-1:0] SIG_INF = {1'b1, {(SIG_W-1){1'b0}}};

  logic [OP_W-1:0] ops     [2];
  cmpInfo_t        cInfo   [2];
  clsInfo_t        kInfo   [2];

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar g = 0; g < 2; g++) begin : g_decode
    logic [EXP_W-1:0] expv;
    logic [SIG_W-1:0] sigv;
    logic expMax, expNil, sigNil, sigInfPat;
    assign expv      = ops[g][OP_W-2 -: EXP_W];
    assign sigv      = ops[g][SIG_W-1:0];
    assign expMax    = &expv;
    assign expNil    = ~|expv;
    assign sigNil    = ~|sigv;
    assign sigInfPat = (sigv == SIG_INF);
    assign cInfo[g] = '{isNan:  expMax & ~sigInfPat,
                        isSnan: expMax & ~sigInfPat & ~sigv[QBIT],
                        isZero: expNil & sigNil,
                        sign:   ops[g][OP_W-1]};
    assign kInfo[g] = '{isNan:    expMax & ~sigInfPat,
                        isInf:    expMax & sigInfPat,
                        isZero:   expNil & sigNil,
                        isDenorm: expNil & ~sigNil};
  end

  assign infoA = cInfo[0];
  assign infoB = cInfo[1];
  assign clsA  = kInfo[0];

  // exponent then significand: one unsigned compare of the concatenation
  assign magLess  = opA[OP_W-2:0] <  opB[OP_W-2:0];
  assign magEqual = opA[OP_W-2:0] == opB[OP_W-2:0];

  always_comb begin
    cmpCond  = '0;
    cmpFlags = '0;
    if (strobe.selLess) begin
      cmpCond[C0_POS]  = 1'b1;
      cmpFlags[CF_POS] = 1'b1;
    end
    if (strobe.selEqual) begin
      cmpCond[C3_POS]  = 1'b1;
      cmpFlags[ZF_POS] = 1'b1;
    end
    if (strobe.selUnord) begin
      cmpCond[C3_POS]  = 1'b1;
      cmpCond[C2_POS]  = 1'b1;
      cmpCond[C0_POS]  = 1'b1;
      cmpFlags[ZF_POS] = 1'b1;
      cmpFlags[PF_POS] = 1'b1;
      cmpFlags[CF_POS] = 1'b1;
    end
  end

  always_comb begin
    classCond = '0;
    classCond[C1_POS] = cInfo[0].sign;
    unique case (strobe.clsKind)
      CLS_NAN:    classCond[C0_POS] = 1'b1;
      CLS_INF:    begin classCond[C2_POS] = 1'b1; classCond[C0_POS] = 1'b1; end
      CLS_ZERO:   classCond[C3_POS] = 1'b1;
      CLS_DENORM: begin classCond[C3_POS] = 1'b1; classCond[C2_POS] = 1'b1; end
      default:    classCond[C2_POS] = 1'b1;
    endcase
  end
endmodule

// File: rtl/xcc_ctrl.sv
module xcc_ctrl
  import xcc_pkg::*;
(
  input  cmpInfo_t   infoA,
  input  cmpInfo_t   infoB,
  input  clsInfo_t   clsA,
  input  logic       magLess,
  input  logic       magEqual,
  input  logic       quietCmp,
  output xccStrobe_t strobe
);
  logic unord, bothZero;

  assign unord    = infoA.isNan | infoB.isNan;
  assign bothZero = infoA.isZero & infoB.isZero;

  always_comb begin
    strobe = '{selLess: 1'b0, selEqual: 1'b0, selUnord: 1'b0,
               raiseInv: 1'b0, clsKind: CLS_NORMAL};
    strobe.raiseInv = quietCmp ? (infoA.isSnan | infoB.isSnan) : unord;
    if (unord)                        strobe.selUnord = 1'b1;
    else if (bothZero)                strobe.selEqual = 1'b1;
    else if (infoA.sign != infoB.sign) strobe.selLess = infoA.sign;
    else if (magEqual)                strobe.selEqual = 1'b1;
    else                              strobe.selLess  = magLess ^ infoA.sign;

    if (clsA.isNan)         strobe.clsKind = CLS_NAN;
    else if (clsA.isInf)    strobe.clsKind = CLS_INF;
    else if (clsA.isZero)   strobe.clsKind = CLS_ZERO;
    else if (clsA.isDenorm) strobe.clsKind = CLS_DENORM;
  end
endmodule

// File: rtl/xcc_compare_classify.sv
module xcc_compare_classify
  import xcc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [1+EXP_W+SIG_W-1:0] opA,
  input  logic [1+EXP_W+SIG_W-1:0] opB,
  input  logic                     quietCmp,
  output logic [STAT_W-1:0]        cmpCond,
  output logic [FLAG_W-1:0]        cmpFlags,
  output logic                     cmpInvalid,
  output logic [STAT_W-1:0]        classCond
);
  cmpInfo_t   infoA, infoB;
  clsInfo_t   clsA;
  logic       magLess, magEqual;
  xccStrobe_t strobe;

  xcc_datapath #(.EXP_W(EXP_W), .SIG_W(SIG_W)) datapath_i (
    .opA(opA), .opB(opB), .strobe(strobe),
    .infoA(infoA), .infoB(infoB), .clsA(clsA),
    .magLess(magLess), .magEqual(magEqual),
    .cmpCond(cmpCond), .cmpFlags(cmpFlags), .classCond(classCond)
  );

  xcc_ctrl ctrl_i (
    .infoA(infoA), .infoB(infoB), .clsA(clsA),
    .magLess(magLess), .magEqual(magEqual),
    .quietCmp(quietCmp), .strobe(strobe)
  );

  assign cmpInvalid = strobe.raiseInv;
endmodule

// File: rtl/xcc_compare_classify_chk.sv
module xcc_compare_classify_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic [1+EXP_W+SIG_W-1:0] opA,
  input logic [1+EXP_W+SIG_W-1:0] opB,
  input logic                     quietCmp,
  input logic [15:0]              cmpCond,
  input logic [7:0]               cmpFlags,
  input logic                     cmpInvalid,
  input logic [15:0]              classCond
);
  localparam int OP_W = 1 + EXP_W + SIG_W;
  localparam logic [SIG_W-1:0] SIG_INF = {1'b1, {(SIG_W-1){1'b0}}};

  logic nanA, nanB, known;
  logic [15:0] clsCode;
  assign nanA = (&opA[OP_W-2 -: EXP_W]) && (opA[SIG_W-1:0] != SIG_INF);
  assign nanB = (&opB[OP_W-2 -: EXP_W]) && (opB[SIG_W-1:0] != SIG_INF);
  assign known = !$isunknown({opA, opB, quietCmp, cmpCond, cmpFlags, cmpInvalid, classCond});
  assign clsCode = classCond & ~16'h0200;

  always_comb begin
    if (known) begin
      assert_cond_mask_R5: assert ((cmpCond & ~16'h4500) == 16'h0 && (cmpFlags & ~8'h45) == 8'h0);
      assert_flag_mirror_R5: assert (cmpFlags[0] == cmpCond[8] && cmpFlags[2] == cmpCond[10]
                                     && cmpFlags[6] == cmpCond[14]);
      assert_inv_only_unord_R7: assert (!cmpInvalid || cmpCond == 16'h4500);
      assert_sig_nan_inv_R7: assert (quietCmp || !(nanA || nanB) || cmpInvalid);
      assert_self_equal_R2: assert (opA != opB || nanA || cmpCond == 16'h4000);
      assert_nan_unord_R4: assert (!(nanA || nanB) || cmpCond == 16'h4500);
      assert_class_sign_R13: assert (classCond[9] == opA[OP_W-1] && (classCond & ~16'h4700) == 16'h0);
      assert_class_legal_R9: assert (clsCode == 16'h0500 || clsCode == 16'h0100 || clsCode == 16'h4000
                                     || clsCode == 16'h4400 || clsCode == 16'h0400);
    end
  end
endmodule

bind xcc_compare_classify xcc_compare_classify_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) chk_i (
  .opA(opA), .opB(opB), .quietCmp(quietCmp), .cmpCond(cmpCond),
  .cmpFlags(cmpFlags), .cmpInvalid(cmpInvalid), .classCond(classCond)
);

// File: tb/xcc_compare_classify_tb.sv
module xcc_compare_classify_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [79:0] ONE   = {1'b0, 15'h3FFF, 64'h8000000000000000};
  localparam logic [79:0] ONEUP = {1'b0, 15'h3FFF, 64'h8000000000000001};
  localparam logic [79:0] TWO   = {1'b0, 15'h4000, 64'h8000000000000000};
  localparam logic [79:0] NONE  = {1'b1, 15'h3FFF, 64'h8000000000000000};
  localparam logic [79:0] NTWO  = {1'b1, 15'h4000, 64'h8000000000000000};
  localparam logic [79:0] PZ    = 80'h0;
  localparam logic [79:0] NZ    = {1'b1, 79'h0};
  localparam logic [79:0] PINF  = {1'b0, 15'h7FFF, 64'h8000000000000000};
  localparam logic [79:0] NINF  = {1'b1, 15'h7FFF, 64'h8000000000000000};
  localparam logic [79:0] QNAN  = {1'b0, 15'h7FFF, 64'hC000000000000000};
  localparam logic [79:0] SNAN  = {1'b0, 15'h7FFF, 64'hA000000000000000};
  localparam logic [79:0] ZNAN  = {1'b0, 15'h7FFF, 64'h0};
  localparam logic [79:0] DEN   = {1'b0, 15'h0000, 64'h0000000000000001};

  typedef struct packed {
    logic [15:0] tag;
    logic [79:0] a;
    logic [79:0] b;
    logic        q;
    logic [15:0] cond;
    logic [7:0]  flags;
    logic        inv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{"R1", ONE,  TWO,   1'b0, 16'h0100, 8'h01, 1'b0},
    '{"R3", TWO,  ONE,   1'b0, 16'h0000, 8'h00, 1'b0},
    '{"R2", ONE,  ONE,   1'b0, 16'h4000, 8'h40, 1'b0},
    '{"R2", PZ,   NZ,    1'b0, 16'h4000, 8'h40, 1'b0},
    '{"R6", NONE, NTWO,  1'b0, 16'h0000, 8'h00, 1'b0},
    '{"R6", NTWO, ONE,   1'b1, 16'h0100, 8'h01, 1'b0},
    '{"R1", ONE,  ONEUP, 1'b0, 16'h0100, 8'h01, 1'b0},
    '{"R7", QNAN, ONE,   1'b0, 16'h4500, 8'h45, 1'b1},
    '{"R8", ONE,  QNAN,  1'b1, 16'h4500, 8'h45, 1'b0},
    '{"R8", SNAN, ONE,   1'b1, 16'h4500, 8'h45, 1'b1},
    '{"R4", ONE,  ZNAN,  1'b0, 16'h4500, 8'h45, 1'b1},
    '{"R3", PINF, TWO,   1'b0, 16'h0000, 8'h00, 1'b0},
    '{"R6", NZ,   DEN,   1'b0, 16'h0100, 8'h01, 1'b0},
    '{"R6", NINF, NTWO,  1'b1, 16'h0100, 8'h01, 1'b0}
  };

  typedef struct packed {
    logic [15:0] tag;
    logic [79:0] a;
    logic [15:0] cls;
  } cvec_t;

  localparam int NC = 9;
  localparam cvec_t CVECS [NC] = '{
    '{"R9",  PINF, 16'h0500},
    '{"R13", NINF, 16'h0700},
    '{"R10", QNAN, 16'h0100},
    '{"R10", ZNAN, 16'h0100},
    '{"R11", PZ,   16'h4000},
    '{"R13", NZ,   16'h4200},
    '{"R11", DEN,  16'h4400},
    '{"R12", ONE,  16'h0400},
    '{"R13", NONE, 16'h0600}
  };

  logic        clk = 1'b0;
  logic [79:0] opA = '0;
  logic [79:0] opB = '0;
  logic        quietCmp = 1'b0;
  logic [15:0] cmpCond, classCond;
  logic [7:0]  cmpFlags;
  logic        cmpInvalid;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcc_compare_classify dut_i (
    .opA(opA), .opB(opB), .quietCmp(quietCmp),
    .cmpCond(cmpCond), .cmpFlags(cmpFlags),
    .cmpInvalid(cmpInvalid), .classCond(classCond)
  );

  task automatic check(input logic [15:0] tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [79:0] a, input logic [79:0] b, input logic q);
    @(negedge clk);
    opA = a; opB = b; quietCmp = q;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    // idle state with all-zero inputs: equal compare, zero class
    #(CLK_PERIOD/4);
    check("R2", "idle cond", cmpCond, 16'h4000);
    check("R11", "idle class", classCond, 16'h4000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].q);
      check(VECS[i].tag, "cond", cmpCond, VECS[i].cond);
      check(VECS[i].tag, "flags", {8'h0, cmpFlags}, {8'h0, VECS[i].flags});
      check(VECS[i].tag, "invalid", {15'h0, cmpInvalid}, {15'h0, VECS[i].inv});
      check("R5", "cond mask", cmpCond & ~16'h4500, 16'h0);
    end

    for (int i = 0; i < NC; i++) begin
      apply(CVECS[i].a, ONE, 1'b0);
      check(CVECS[i].tag, "class", classCond, CVECS[i].cls);
    end

    // directed corners
    apply(QNAN, QNAN, 1'b1);
    check("R8", "two quiet NaNs no invalid", {15'h0, cmpInvalid}, 16'h0);
    apply(ONE, SNAN, 1'b0);
    check("R7", "signalling NaN signalling mode", {15'h0, cmpInvalid}, 16'h1);
    apply(NZ, PZ, 1'b1);
    check("R2", "minus zero vs plus zero", cmpCond, 16'h4000);
    apply(NTWO, NONE, 1'b0);
    check("R6", "both negative inverted", cmpCond, 16'h0100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule